// File: doc/BRIEF.md
# Single-to-half precision float converter

This block narrows a 32-bit IEEE-754 single-precision word to a 16-bit half-precision word with round-to-nearest-even. Each cycle it takes one input word with a valid strobe. One clock later it presents the narrowed word together with a matching valid strobe. The datapath is a single combinational stage followed by one output register. A new word can enter on every clock.

The unit sorts each input into one of a few classes:

- Zero, or a single-precision subnormal. Both flush to a signed zero.
- Infinity or NaN. A NaN is forced quiet and keeps the upper part of its payload.
- Too small for half precision. The result is a signed zero.
- Half-precision subnormal range. The result is rounded after a variable right shift.
- Normal range. The result is rebiased and rounded, and the rounding can carry into the exponent.
- Too large for half precision. The result is a signed infinity.

The sign is always copied straight through.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous clock edge. `f16_o` holds the conversion of the `f32_i` word sampled at that edge. `f16_o` updates on every edge whatever the value of `valid_i`.
- R2: An input whose exponent field (bits 30:23) is 0 gives an output with bits 14:0 all zero.
- R3: An input with exponent field 255 and mantissa (bits 22:0) zero gives 0x7C00 with the sign in bit 15.
- R4: An input with exponent field 255 and a nonzero mantissa gives an output whose bits 14:10 are 11111. Its bits 9:0 are input bits 22:13 with bit 9 forced to 1.
- R5: An exponent field from 143 to 254 gives a signed infinity (bits 14:0 = 0x7C00).
- R6: An exponent field from 1 to 101 gives a signed zero.
- R7: For an exponent field e from 102 to 112, the process has these steps:
  - A 1 is placed above the 23 mantissa bits to form a 24-bit significand.
  - The significand is shifted right by 126 − e to give the value in bits 9:0.
  - The last bit shifted out is the round bit.
  - Every lower bit shifted out is ORed into a sticky bit.
  - The value is incremented when the round bit is 1 and either the sticky bit or the kept LSB is 1.
  - Bits 14:10 are 0.
- R8: When the rounding of R7 reaches 0x400, the output is 0x0400 with the sign, the smallest normal number.
- R9: For an exponent field e from 113 to 142:
  - Bits 14:10 are e − 112.
  - Bits 9:0 are input bits 22:13, rounded up when input bits 12:0 exceed 0x1000, or equal 0x1000 with input bit 13 set.
- R10: A rounding carry out of the 10-bit mantissa clears the mantissa and adds one to the exponent. If the exponent then reaches 31, the output is a signed infinity.
- R11: While `rst_ni` is low, `valid_o` and `f16_o` are cleared to 0, without waiting for a clock.
- R12: Output bit 15 always equals input bit 31 of the converted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word qualifier |
| f32_i | input | 32 | Single-precision input word |
| valid_o | output | 1 | Output word qualifier, one cycle after `valid_i` |
| f16_o | output | 16 | Half-precision result |

## Verification
Fixed vectors target every class boundary:

- Exponent fields 101 and 102, 112 and 113, 142 and 143 separate flush, subnormal, normal and overflow handling.
- Exact ties with an even and an odd kept LSB, and ties with one extra sticky bit, tell true nearest-even rounding apart from truncation and from round-half-up.
- Mantissas of all ones in the subnormal range and at the top exponent show that a rounding carry reaches the smallest normal or infinity.
- NaN payloads with the quiet bit clear and with payload only in the low bits show that quieting is forced.

A few hundred random words are then compared against a model written in the bench, with weight placed on exponents near the class limits.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int IN_EXP_W  = 8;
  localparam int IN_MAN_W  = 23;
  localparam int OUT_EXP_W = 5;
  localparam int OUT_MAN_W = 10;
  localparam int IN_W      = 1 + IN_EXP_W + IN_MAN_W;
  localparam int OUT_W     = 1 + OUT_EXP_W + OUT_MAN_W;
  localparam int IN_BIAS   = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS  = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = IN_BIAS - OUT_BIAS;
  localparam int DROP_W    = IN_MAN_W - OUT_MAN_W;
  localparam int SIG_W     = IN_MAN_W + 1;
  localparam int SUB_W     = OUT_MAN_W + 1;
  localparam int WE_W      = IN_EXP_W + 2;
  localparam int SH_W      = $clog2(SIG_W + 1);
  localparam int EXP_MAX   = (1 << OUT_EXP_W) - 1;

  typedef struct packed {
    logic                sign;
    logic [IN_EXP_W-1:0] exp;
    logic [IN_MAN_W-1:0] man;
  } f32_t;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_INF,
    CLS_NAN,
    CLS_TINY,
    CLS_SUB,
    CLS_NORM,
    CLS_HUGE
  } cls_e;
endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
  import f2h_pkg::*;
(
  input  logic [IN_EXP_W-1:0]   exp_i,
  input  logic                  man_nz_i,
  output cls_e                  cls_o,
  output logic signed [WE_W-1:0] we_o
);
  localparam logic signed [WE_W-1:0] SUB_LO = -(WE_W'(OUT_MAN_W));
  localparam logic signed [WE_W-1:0] HUGE_LO = WE_W'(EXP_MAX);

  assign we_o = $signed({2'b00, exp_i}) - $signed(WE_W'(BIAS_DIFF));

  always_comb begin
    if (exp_i == '0)             cls_o = CLS_ZERO;
    else if (exp_i == '1)        cls_o = man_nz_i ? CLS_NAN : CLS_INF;
    else if (we_o < SUB_LO)      cls_o = CLS_TINY;
    else if (we_o <= 0)          cls_o = CLS_SUB;
    else if (we_o >= HUGE_LO)    cls_o = CLS_HUGE;
    else                         cls_o = CLS_NORM;
  end
endmodule

// File: rtl/f2h_sub_rnd.sv
module f2h_sub_rnd
  import f2h_pkg::*;
(
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [SUB_W-1:0] mant_o
);
  logic [SIG_W-1:0] kept;
  logic [SIG_W-1:0] below_mask;
  logic             rbit;
  logic             sticky;
  logic             inc;

  always_comb begin
    kept       = sig_i >> shamt_i;
    rbit       = sig_i[shamt_i - SH_W'(1)];
    below_mask = (SIG_W'(1) << (shamt_i - SH_W'(1))) - SIG_W'(1);
    sticky     = |(sig_i & below_mask);
    inc        = rbit & (sticky | kept[0]);
    // a carry to bit OUT_MAN_W lands exactly on the smallest normal
    mant_o     = SUB_W'(kept) + SUB_W'(inc);
  end
endmodule

// File: rtl/f2h_norm_rnd.sv
module f2h_norm_rnd
  import f2h_pkg::*;
(
  input  logic [IN_MAN_W-1:0]  man_i,
  input  logic [OUT_EXP_W-1:0] exp_i,
  output logic [OUT_EXP_W-1:0] exp_o,
  output logic [OUT_MAN_W-1:0] mant_o,
  output logic                 ovf_o
);
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic [DROP_W-1:0]  rem;
  logic [OUT_MAN_W-1:0] kept;
  logic               up;
  logic [OUT_MAN_W:0] sum;
  logic               carry;

  always_comb begin
    rem    = man_i[DROP_W-1:0];
    kept   = man_i[IN_MAN_W-1:DROP_W];
    up     = (rem > HALF) || ((rem == HALF) && kept[0]);
    sum    = {1'b0, kept} + (OUT_MAN_W+1)'(up);
    carry  = sum[OUT_MAN_W];
    mant_o = sum[OUT_MAN_W-1:0];
    exp_o  = exp_i + OUT_EXP_W'(carry);
    ovf_o  = (exp_o == '1);
  end
endmodule

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt
  import f2h_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  f32_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] f16_o
);
  localparam logic [OUT_MAN_W-1:0] QUIET = {1'b1, {(OUT_MAN_W-1){1'b0}}};

  f32_t                  f;
  cls_e                  cls;
  logic signed [WE_W-1:0] we;
  logic [SH_W-1:0]       shamt;
  logic [SUB_W-1:0]      sub_mant;
  logic [OUT_EXP_W-1:0]  nrm_exp;
  logic [OUT_MAN_W-1:0]  nrm_mant;
  logic                  nrm_ovf;
  logic [OUT_W-1:0]      res;

  assign f = f32_i;

  f2h_classify u_cls (
    .exp_i    (f.exp),
    .man_nz_i (|f.man),
    .cls_o    (cls),
    .we_o     (we)
  );

  // right shift that lands the hidden one on the subnormal grid
  assign shamt = SH_W'(WE_W'(OUT_MAN_W + DROP_W - 9) - we);

  f2h_sub_rnd u_sub (
    .sig_i   ({1'b1, f.man}),
    .shamt_i (shamt),
    .mant_o  (sub_mant)
  );

  f2h_norm_rnd u_nrm (
    .man_i  (f.man),
    .exp_i  (OUT_EXP_W'(we)),
    .exp_o  (nrm_exp),
    .mant_o (nrm_mant),
    .ovf_o  (nrm_ovf)
  );

  always_comb begin
    unique case (cls)
      CLS_ZERO, CLS_TINY: res = {f.sign, {(OUT_W-1){1'b0}}};
      CLS_INF, CLS_HUGE:  res = {f.sign, {OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}};
      CLS_NAN:            res = {f.sign, {OUT_EXP_W{1'b1}},
                                 f.man[IN_MAN_W-1 -: OUT_MAN_W] | QUIET};
      CLS_SUB:            res = {f.sign, {(OUT_EXP_W-1){1'b0}}, sub_mant};
      default:            res = nrm_ovf ? {f.sign, {OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}}
                                        : {f.sign, nrm_exp, nrm_mant};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      f16_o   <= '0;
    end else begin
      valid_o <= valid_i;
      f16_o   <= res;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] == 8'd0) |=> (f16_o[14:0] == 15'd0)); // R2
  AST_INF_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] == 8'hff && f32_i[22:0] == 23'd0) |=> (f16_o[14:0] == 15'h7c00)); // R3
  AST_NAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] == 8'hff && f32_i[22:0] != 23'd0) |=> (f16_o[14:10] == 5'h1f && f16_o[9])); // R4
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] >= 8'd143 && f32_i[30:23] != 8'hff) |=> (f16_o[14:0] == 15'h7c00)); // R5
  AST_UFL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] != 8'd0 && f32_i[30:23] <= 8'd101) |=> (f16_o[14:0] == 15'd0)); // R6
  AST_SUB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && f32_i[30:23] >= 8'd102 && f32_i[30:23] <= 8'd112) |=> (f16_o[14:0] <= 15'h0400)); // R8
  AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (f16_o[15] == $past(f32_i[31]))); // R12
endmodule

// File: tb/sim_f32_to_f16_cvt.sv
module sim_f32_to_f16_cvt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] f32_i = '0;
  logic        valid_o;
  logic [15:0] f16_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  f32_to_f16_cvt u0 (.*);

  // {input, expected, requirement}
  localparam int NV = 34;
  localparam logic [51:0] VEC [NV] = '{
    {32'h00000000, 16'h0000, 4'd2},   // R2 +0
    {32'h80000000, 16'h8000, 4'd2},   // R2 -0
    {32'h00000001, 16'h0000, 4'd2},   // R2 single subnormal
    {32'h807fffff, 16'h8000, 4'd12},  // R12 sign kept on flush
    {32'h7f800000, 16'h7c00, 4'd3},   // R3 +inf
    {32'hff800000, 16'hfc00, 4'd3},   // R3 -inf
    {32'h7fc00000, 16'h7e00, 4'd4},   // R4 quiet NaN
    {32'h7f800001, 16'h7e00, 4'd4},   // R4 low payload forced quiet
    {32'hffffffff, 16'hffff, 4'd4},   // R4 full payload
    {32'h7fa00000, 16'h7f00, 4'd4},   // R4 signalling payload kept
    {32'h7f7fffff, 16'h7c00, 4'd5},   // R5 max single
    {32'h47800000, 16'h7c00, 4'd5},   // R5 exponent 143
    {32'hc7800000, 16'hfc00, 4'd5},   // R5 negative
    {32'h32800000, 16'h0000, 4'd6},   // R6 exponent 101
    {32'hb2ffffff, 16'h8000, 4'd6},   // R6 negative, full mantissa
    {32'h00800000, 16'h0000, 4'd6},   // R6 exponent 1
    {32'h33800000, 16'h0001, 4'd7},   // R7 2^-24
    {32'h33000000, 16'h0000, 4'd7},   // R7 tie, kept even
    {32'h33000001, 16'h0001, 4'd7},   // R7 tie plus sticky
    {32'h38000000, 16'h0200, 4'd7},   // R7 exponent 112
    {32'h38006000, 16'h0202, 4'd7},   // R7 tie, odd kept rounds up
    {32'h38004000, 16'h0201, 4'd7},   // R7 below half
    {32'h387fffff, 16'h0400, 4'd8},   // R8 to smallest normal
    {32'hb87fffff, 16'h8400, 4'd8},   // R8 negative
    {32'h3f800000, 16'h3c00, 4'd9},   // R9 1.0
    {32'hc0000000, 16'hc000, 4'd9},   // R9 -2.0
    {32'h3f801000, 16'h3c00, 4'd9},   // R9 tie, even stays
    {32'h3f803000, 16'h3c02, 4'd9},   // R9 tie, odd up
    {32'h3f801001, 16'h3c01, 4'd9},   // R9 above half
    {32'h38800000, 16'h0400, 4'd9},   // R9 exponent 113
    {32'h477fe000, 16'h7bff, 4'd9},   // R9 largest finite
    {32'h477fefff, 16'h7bff, 4'd10},  // R10 just below carry
    {32'h477ff000, 16'h7c00, 4'd10},  // R10 carry to infinity
    {32'h3ffff000, 16'h4000, 4'd10}   // R10 carry bumps exponent
  };

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [31:0] a);
    logic s;
    int   e, w, sig, sh, q, low;
    s   = a[31];
    e   = int'(a[30:23]);
    sig = int'({1'b1, a[22:0]});
    if (e == 0) return {s, 15'h0000};
    if (e == 255) begin
      if (a[22:0] == 0) return {s, 15'h7c00};
      return {s, 5'h1f, a[22:13] | 10'h200};
    end
    w = e - 112;
    if (w < -10) return {s, 15'h0000};
    if (w <= 0) begin
      sh = 14 - w;
      q  = sig >> sh;
      if (((sig >> (sh - 1)) & 1) == 1 &&
          (((sig & ((1 << (sh - 1)) - 1)) != 0) || (q & 1) == 1)) q++;
      if (q >= 1024) return {s, 15'h0400};
      return {s, 15'(q)};
    end
    if (w >= 31) return {s, 15'h7c00};
    low = sig & 32'h1fff;
    if (low > 32'h1000 || (low == 32'h1000 && ((sig >> 13) & 1) == 1)) sig += 32'h1000;
    if (((sig >> 24) & 1) == 1) begin
      w++;
      sig = 32'h800000;
      if (w >= 31) return {s, 15'h7c00};
    end
    return {s, 5'(w), 10'((sig >> 13) & 32'h3ff)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(11, {15'd0, valid_o}, 16'd0);  // R11 reset valid
    chk(11, f16_o, 16'h0000);          // R11 reset data
    rst_ni = 1'b1;

    // table walk, one word per cycle
    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1;
      f32_i   = VEC[i][51:20];
      @(negedge clk_i);
      chk(int'(VEC[i][3:0]), f16_o, VEC[i][19:4]);
      chk(1, {15'd0, valid_o}, 16'd1);  // R1
    end

    // R1: data still converted with valid low, valid drops
    valid_i = 1'b0;
    f32_i   = 32'h40400000;  // 3.0
    @(negedge clk_i);
    chk(1, {15'd0, valid_o}, 16'd0);
    chk(1, f16_o, 16'h4200);

    // R1: back-to-back words with alternating valid
    valid_i = 1'b1;
    f32_i   = 32'hbf800000;
    @(negedge clk_i);
    chk(1, {15'd0, valid_o}, 16'd1);
    chk(12, f16_o, 16'hbc00);  // R12

    // R11: asynchronous reset mid-run
    valid_i = 1'b1;
    f32_i   = 32'h3f800000;
    @(negedge clk_i);
    chk(1, f16_o, 16'h3c00);
    #1 rst_ni = 1'b0;
    #1;
    chk(11, {15'd0, valid_o}, 16'd0);
    chk(11, f16_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // random words against the model, biased toward class limits
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 2 == 0) r[30:23] = 8'(98 + ($urandom % 50));
      valid_i = 1'b1;
      f32_i   = r;
      @(negedge clk_i);
      chk(9, f16_o, model(r));  // R7 R9 R10 random
    end

    valid_i = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule